// File: doc/BRIEF.md
# Clock Gear and Peripheral Prescaler Selector

This block models the system clock path of a microcontroller as single-cycle clock-enable strobes on one fast reference clock. The reference stands for the PLL output. The other clock sources are expressed as enable rates relative to it.

A core-rate enable is produced in one of three ways:
- every reference cycle, when the PLL is on;
- one pulse per `PLL_MULT` cycles, for the direct oscillator;
- one pulse per `2*PLL_MULT` cycles, for the halved oscillator.

A programmable gear divides the core enable. A select bit then chooses between the geared enable and an externally supplied low-speed tick to form the system strobe.

A peripheral prescaler enable is derived from either the geared or the undivided core enable, followed by a divide-by-4/2/1 stage. A clock-out strobe mirrors either the system strobe or the low-speed tick.

Gear changes are written into a pending register. They are applied only when the running gear count wraps, so no interval between geared pulses is ever cut short. All control inputs are plain level fields. There is no data stream and no handshake.

Top module: `clk_gear_sel`

## Requirements
- R1: The core enable fires every reference cycle when `pll_on`=1. With `pll_on`=0 it fires once per `PLL_MULT` cycles if `osc_div_bypass`=1, and once per `2*PLL_MULT` cycles if `osc_div_bypass`=0.
- R2: The gear code divides the core enable: 2'b00 by 1, 2'b01 by 2, 2'b10 by 4, 2'b11 by 8. The gear resets to 2'b11.
- R3: A gear value written with `gear_we` does not change the geared rate in the write cycle. It is applied at the next wrap of the gear count, so no geared interval is shortened.
- R4: `sys_stb` follows the geared enable when `sys_use_gear`=1 and follows `slow_tick` when `sys_use_gear`=0, one cycle later.
- R5: The prescaler source is the geared enable when `per_core_src`=0 and the undivided core enable when `per_core_src`=1.
- R6: `per_scale` divides the prescaler source: 2'b00 by 4, 2'b01 by 2, 2'b10 and 2'b11 by 1.
- R7: `cko_stb` equals `sys_stb` when `cko_use_sys`=1 and follows `slow_tick` one cycle later when `cko_use_sys`=0.
- R8: While `rst_n` is low, all three strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock (PLL output rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_on | input | 1 | 1: core enable at the reference rate |
| osc_div_bypass | input | 1 | With PLL off, 1 skips the oscillator halving |
| gear_we | input | 1 | Write strobe for the gear code |
| gear_wdata | input | 2 | New gear code |
| sys_use_gear | input | 1 | 1: system strobe from the gear, 0: from the low-speed tick |
| slow_tick | input | 1 | Low-speed clock enable |
| per_core_src | input | 1 | 1: prescaler fed by the core enable, 0: by the geared enable |
| per_scale | input | 2 | Prescaler divide code |
| cko_use_sys | input | 1 | 1: clock-out follows the system strobe, 0: the low-speed tick |
| sys_stb | output | 1 | System clock enable |
| per_stb | output | 1 | Peripheral prescaler enable |
| cko_stb | output | 1 | Clock-out enable |

## Verification
The bench uses the default `PLL_MULT`=4. This makes the halved oscillator one pulse per 8 reference cycles, so the slowest path (gear 8 and prescaler 4 on the halved source) repeats every 256 cycles. A 1024-cycle counting window therefore holds a whole number of periods for every setting, and exact pulse counts can be expected for all gear, source and prescale combinations. The low-speed tick is generated by the bench once per 32 cycles, which also divides the window evenly.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int GEAR_W  = 2;
  localparam int SCALE_W = 2;

  typedef enum logic [GEAR_W-1:0] {
    GEAR_D1 = 2'b00,
    GEAR_D2 = 2'b01,
    GEAR_D4 = 2'b10,
    GEAR_D8 = 2'b11
  } gear_e;
endpackage

// File: rtl/cg_core_src.sv
module cg_core_src #(
  parameter int PLL_MULT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_on,
  input  logic osc_bypass,
  output logic core_en
);
  localparam int PER_MAX = 2 * PLL_MULT;
  localparam int CW      = (PER_MAX > 1) ? $clog2(PER_MAX) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          hit;

  assign lim     = osc_bypass ? CW'(PLL_MULT - 1) : CW'(PER_MAX - 1);
  assign hit     = (cnt >= lim);
  assign core_en = pll_on | hit;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (pll_on || hit)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // With the PLL off, two core pulses are never back to back (PLL_MULT >= 2).
  assert_osc_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_on && $past(!pll_on) && $past(core_en)) |-> !core_en);
endmodule

// File: rtl/cg_gear.sv
module cg_gear
  import cg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  core_en,
  input  logic  gear_we,
  input  gear_e gear_wd,
  output logic  geared_en
);
  localparam int NCODE  = 1 << GEAR_W;
  localparam int MAXDIV = 1 << (NCODE - 1);
  localparam int CW     = (MAXDIV > 1) ? $clog2(MAXDIV) : 1;

  gear_e         pend;
  gear_e         act;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          wrap;

  assign last      = CW'((32'd1 << act) - 32'd1);
  assign wrap      = core_en && (cnt >= last);
  assign geared_en = wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= GEAR_D8;
      act  <= GEAR_D8;
      cnt  <= '0;
    end else begin
      if (gear_we) pend <= gear_wd;
      if (wrap) begin
        cnt <= '0;
        act <= pend;
      end else if (core_en) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // The active gear only moves at a wrap of the gear count.
  assert_gear_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act) |-> $past(wrap));

  // The running count stays inside the active division.
  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last);
endmodule

// File: rtl/cg_presc.sv
module cg_presc
  import cg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_en,
  input  logic [SCALE_W-1:0] scale,
  output logic               stb
);
  logic [1:0] cnt;
  logic [1:0] last;

  always_comb begin
    case (scale)
      2'b00:   last = 2'd3;
      2'b01:   last = 2'd1;
      default: last = 2'd0;
    endcase
  end

  assign stb = src_en && (cnt >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (stb)    cnt <= '0;
    else if (src_en) cnt <= cnt + 1'b1;
  end

  // Divide-by-4 setting never emits on a source pulse that started a count.
  assert_div4_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scale == 2'b00 && $past(scale == 2'b00) && $past(stb)) |-> !stb);
endmodule

// File: rtl/clk_gear_sel.sv
module clk_gear_sel
  import cg_pkg::*;
#(
  parameter int PLL_MULT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pll_on,
  input  logic       osc_div_bypass,
  input  logic       gear_we,
  input  logic [1:0] gear_wdata,
  input  logic       sys_use_gear,
  input  logic       slow_tick,
  input  logic       per_core_src,
  input  logic [1:0] per_scale,
  input  logic       cko_use_sys,
  output logic       sys_stb,
  output logic       per_stb,
  output logic       cko_stb
);
  logic core_en;
  logic geared_en;
  logic per_src_en;
  logic per_en;
  logic sys_next;
  logic live;

  cg_core_src #(.PLL_MULT(PLL_MULT)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .pll_on     (pll_on),
    .osc_bypass (osc_div_bypass),
    .core_en    (core_en)
  );

  cg_gear u_gear (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_en   (core_en),
    .gear_we   (gear_we),
    .gear_wd   (gear_e'(gear_wdata)),
    .geared_en (geared_en)
  );

  assign per_src_en = per_core_src ? core_en : geared_en;

  cg_presc u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_en (per_src_en),
    .scale  (per_scale),
    .stb    (per_en)
  );

  assign sys_next = sys_use_gear ? geared_en : slow_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_stb <= 1'b0;
      per_stb <= 1'b0;
      cko_stb <= 1'b0;
      live    <= 1'b0;
    end else begin
      sys_stb <= sys_next;
      per_stb <= per_en;
      cko_stb <= cko_use_sys ? sys_next : slow_tick;
      live    <= 1'b1;
    end
  end

  assert_sys_slow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(sys_use_gear)) |-> (sys_stb == $past(slow_tick)));

  assert_cko_slow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(cko_use_sys)) |-> (cko_stb == $past(slow_tick)));

  assert_cko_sys_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(cko_use_sys)) |-> (cko_stb == sys_stb));
endmodule

// File: tb/sim_clk_gear_sel.sv
module sim_clk_gear_sel;
  localparam int PLL_MULT = 4;
  localparam int WIN      = 1024;
  localparam int SETTLE   = 700;
  localparam int SLOW_PER = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pll_on = 1'b1;
  logic       osc_div_bypass = 1'b0;
  logic       gear_we = 1'b0;
  logic [1:0] gear_wdata = 2'b11;
  logic       sys_use_gear = 1'b1;
  logic       slow_tick = 1'b0;
  logic       per_core_src = 1'b0;
  logic [1:0] per_scale = 2'b00;
  logic       cko_use_sys = 1'b1;
  logic       sys_stb, per_stb, cko_stb;

  int checks = 0;
  int errors = 0;
  int scnt = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    scnt      <= (scnt == SLOW_PER - 1) ? 0 : scnt + 1;
    slow_tick <= (scnt == SLOW_PER - 1);
  end

  clk_gear_sel #(.PLL_MULT(PLL_MULT)) u0 (
    .clk(clk), .rst_n(rst_n), .pll_on(pll_on), .osc_div_bypass(osc_div_bypass),
    .gear_we(gear_we), .gear_wdata(gear_wdata), .sys_use_gear(sys_use_gear),
    .slow_tick(slow_tick), .per_core_src(per_core_src), .per_scale(per_scale),
    .cko_use_sys(cko_use_sys), .sys_stb(sys_stb), .per_stb(per_stb), .cko_stb(cko_stb)
  );

  function automatic int core_per(input bit pll, input bit byp);
    return pll ? 1 : (byp ? PLL_MULT : 2 * PLL_MULT);
  endfunction

  function automatic int scale_div(input logic [1:0] s);
    return (s == 2'b00) ? 4 : ((s == 2'b01) ? 2 : 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_gear(input logic [1:0] g);
    @(negedge clk);
    gear_we = 1'b1; gear_wdata = g;
    @(negedge clk);
    gear_we = 1'b0;
  endtask

  task automatic run_cfg(input bit pll, input bit byp, input logic [1:0] g,
                         input bit ug, input bit pc, input logic [1:0] sc,
                         input bit ck, input string tag);
    int ns, np, nc, cp, gp, sp, pp;
    pll_on = pll; osc_div_bypass = byp; sys_use_gear = ug;
    per_core_src = pc; per_scale = sc; cko_use_sys = ck;
    write_gear(g);
    repeat (SETTLE) @(negedge clk);
    ns = 0; np = 0; nc = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      ns += int'(sys_stb); np += int'(per_stb); nc += int'(cko_stb);
    end
    cp = core_per(pll, byp);
    gp = cp * (1 << g);
    sp = ug ? gp : SLOW_PER;
    pp = (pc ? cp : gp) * scale_div(sc);
    chk({"R1 R2 R4 sys ", tag}, ns, WIN / sp);
    chk({"R5 R6 per ", tag}, np, WIN / pp);
    chk({"R7 cko ", tag}, nc, WIN / (ck ? sp : SLOW_PER));
  endtask

  initial begin
    int early;
    void'($urandom(32'd1234));
    // R8: strobes low in reset
    repeat (20) begin
      @(negedge clk);
      chk("R8 reset", int'(sys_stb) + int'(per_stb) + int'(cko_stb), 0);
    end
    rst_n = 1'b1;
    // R2: reset gear is divide by 8 (PLL on, geared system, default prescale /4)
    begin
      int n = 0;
      repeat (64) @(negedge clk);
      for (int i = 0; i < WIN; i++) begin
        @(negedge clk);
        n += int'(sys_stb);
      end
      chk("R2 reset gear /8", n, WIN / 8);
    end
    // R3: a write does not take effect in its own cycle
    @(negedge clk);
    while (!sys_stb) @(negedge clk);
    gear_we = 1'b1; gear_wdata = 2'b00;
    @(negedge clk);
    gear_we = 1'b0;
    early = 0;
    for (int i = 0; i < 5; i++) begin
      early += int'(sys_stb);
      @(negedge clk);
    end
    chk("R3 gear latency", early, 0);
    // Directed corners
    run_cfg(1, 0, 2'b00, 1, 0, 2'b10, 1, "pll /1 scale1");
    run_cfg(0, 0, 2'b11, 1, 0, 2'b00, 1, "halved /8 scale4");
    run_cfg(0, 1, 2'b01, 1, 1, 2'b01, 0, "direct /2 core src");
    run_cfg(1, 0, 2'b10, 0, 1, 2'b11, 1, "slow sys");
    run_cfg(0, 0, 2'b00, 1, 1, 2'b00, 0, "halved core scale4");
    run_cfg(1, 1, 2'b11, 1, 0, 2'b01, 1, "pll bypass ignored");
    // Constrained random
    for (int k = 0; k < 10; k++) begin
      run_cfg($urandom % 2, $urandom % 2, 2'($urandom % 4), $urandom % 2,
              $urandom % 2, 2'($urandom % 4), $urandom % 2, "random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule